// File: doc/BRIEF.md
# Microstep Phase Current Sequencer

This block produces the current set-points for the two windings of a stepper motor driven in 64-division microstep mode. It holds a 6-bit electrical position. Each cycle in which the enable input is high and a step pulse is present, the position moves one place forward or back, as the direction input selects, and it wraps at both ends of the cycle. The position indexes a quarter-wave table of 17 percent-scaled entries. Quadrant folding turns this table into the full cycle, so the two phase currents trace a vector of close to constant length.

Each phase is presented as an unsigned magnitude from 0 to 100 and a separate sign bit, which is the form a PWM chopper stage downstream expects. When the enable input is low, the position is frozen and both magnitudes are forced to zero, so the windings carry no current. The position is also brought out so that the controlling logic can track the rotor's electrical angle.

Top module: `ustep_phase_seq`

## Requirements
- R1: After the active-low asynchronous reset, the position is 0. With enable high, phase A is then magnitude 0 and positive, and phase B is magnitude 100 and positive.
- R2: With enable high, step high and direction 1, the position increases by one at the clock edge, and 63 is followed by 0.
- R3: With enable high, step high and direction 0, the position decreases by one at the clock edge, and 0 is followed by 63.
- R4: The position does not change in any cycle where step is low or enable is low, whatever the direction input.
- R5: While enable is low, both magnitude outputs are 0.
- R6: For positions k = 0 to 16, the phase-A magnitude is k→ 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100.
- R7: For positions k = 0 to 16, the phase-B magnitude equals the phase-A magnitude of position 16−k.
- R8: The quadrant q is position bits [5:4] and the offset f is bits [3:0]. When q is even, A takes table entry f and B takes entry 16−f. When q is odd, A takes entry 16−f and B takes entry f.
- R9: The sign bits use 1 for negative. The A sign is 1 for quadrants 2 and 3. The B sign is 1 for quadrants 1 and 2. The sign bits follow the position even when enable is low.
- R10: With enable high, the sum of the squares of the two magnitudes stays between 9800 and 10200 at every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Drive enable; low freezes the position and zeroes the currents |
| step_i | input | 1 | Step request, sampled at the clock edge |
| dir_i | input | 1 | 1 = forward (increment), 0 = reverse (decrement) |
| pos_o | output | 6 | Current electrical position |
| a_mag_o | output | 7 | Phase-A current magnitude, percent |
| a_neg_o | output | 1 | Phase-A sign, 1 = negative |
| b_mag_o | output | 7 | Phase-B current magnitude, percent |
| b_neg_o | output | 1 | Phase-B sign, 1 = negative |

## Verification
Two functions can land in the same cycle. The first pair is a step request and a falling enable: the bench drives step high in the cycle that enable drops, then checks that the position holds and that both magnitudes read zero while the sign bits stay on the frozen quadrant. The second pair is a wrap and a change of direction: the bench steps across the 63/0 seam in both directions, reversing right at the seam, and checks each position against an arithmetic model of the modular index, the table fold and the sign rules.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned QTR_W      = IDX_W - 2;
  localparam int unsigned QTR_STEPS  = 1 << QTR_W;
  localparam int unsigned MAG_W      = 7;
  localparam int unsigned FULL_SCALE = 100;

  typedef logic [IDX_W-1:0] pos_t;
  typedef logic [QTR_W:0]   qpos_t;
  typedef logic [MAG_W-1:0] mag_t;

  // quarter-wave sine, percent, entries 0..QTR_STEPS
  function automatic mag_t qsine(input qpos_t k);
    case (k)
      5'd0:    qsine = 7'd0;
      5'd1:    qsine = 7'd10;
      5'd2:    qsine = 7'd20;
      5'd3:    qsine = 7'd29;
      5'd4:    qsine = 7'd38;
      5'd5:    qsine = 7'd47;
      5'd6:    qsine = 7'd56;
      5'd7:    qsine = 7'd63;
      5'd8:    qsine = 7'd71;
      5'd9:    qsine = 7'd77;
      5'd10:   qsine = 7'd83;
      5'd11:   qsine = 7'd88;
      5'd12:   qsine = 7'd92;
      5'd13:   qsine = 7'd96;
      5'd14:   qsine = 7'd98;
      default: qsine = 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/ustep_index.sv
module ustep_index
  import ustep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic dir_i,
  output pos_t pos_o
);
  pos_t pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_q <= '0;
    else if (en_i && step_i)  pos_q <= dir_i ? pos_q + pos_t'(1) : pos_q - pos_t'(1);
  end

  assign pos_o = pos_q;

  assert_fwd_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && dir_i) |=> (pos_q == pos_t'($past(pos_q) + 1)));

  assert_rev_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && !dir_i) |=> (pos_q == pos_t'($past(pos_q) - 1)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && step_i) |=> $stable(pos_q));
endmodule

// File: rtl/ustep_qtable.sv
module ustep_qtable
  import ustep_pkg::*;
(
  input  qpos_t k_i,
  output mag_t  mag_o
);
  assign mag_o = qsine(k_i);
endmodule

// File: rtl/ustep_fold.sv
module ustep_fold
  import ustep_pkg::*;
(
  input  pos_t pos_i,
  input  logic en_i,
  output mag_t a_mag_o,
  output logic a_neg_o,
  output mag_t b_mag_o,
  output logic b_neg_o
);
  localparam int unsigned NPH = 2;

  logic [1:0] quad;
  qpos_t      off, off_mir;
  mag_t       mag_raw [NPH];

  assign quad    = pos_i[IDX_W-1 -: 2];
  assign off     = {1'b0, pos_i[QTR_W-1:0]};
  assign off_mir = qpos_t'(QTR_STEPS) - off;

  // phase 0 = A reads mirrored in odd quadrants, phase 1 = B the opposite
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic  mir;
    qpos_t k;
    assign mir = (p == 0) ? quad[0] : ~quad[0];
    assign k   = mir ? off_mir : off;
    ustep_qtable u_tab (.k_i(k), .mag_o(mag_raw[p]));
  end

  assign a_mag_o = en_i ? mag_raw[0] : '0;
  assign b_mag_o = en_i ? mag_raw[1] : '0;
  assign a_neg_o = quad[1];
  assign b_neg_o = quad[1] ^ quad[0];
endmodule

// File: rtl/ustep_phase_seq.sv
module ustep_phase_seq
  import ustep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       step_i,
  input  logic       dir_i,
  output logic [5:0] pos_o,
  output logic [6:0] a_mag_o,
  output logic       a_neg_o,
  output logic [6:0] b_mag_o,
  output logic       b_neg_o
);
  pos_t pos;

  ustep_index u_idx (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .step_i(step_i), .dir_i(dir_i), .pos_o(pos)
  );

  ustep_fold u_fold (
    .pos_i  (pos),    .en_i   (en_i),
    .a_mag_o(a_mag_o), .a_neg_o(a_neg_o),
    .b_mag_o(b_mag_o), .b_neg_o(b_neg_o)
  );

  assign pos_o = pos;

  logic [15:0] vec_sq;
  assign vec_sq = 16'(a_mag_o) * 16'(a_mag_o) + 16'(b_mag_o) * 16'(b_mag_o);

  assert_off_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (a_mag_o == '0 && b_mag_o == '0));

  assert_vector_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (vec_sq >= 16'd9800 && vec_sq <= 16'd10200));

  assert_axis_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && a_mag_o == '0) |-> (b_mag_o == 7'(FULL_SCALE)));
endmodule

// File: tb/tb_ustep_phase_seq.sv
module tb_ustep_phase_seq;
  logic clk = 0, rst_n = 0, en = 0, step = 0, dir = 1;
  logic [5:0] pos;
  logic [6:0] am, bm;
  logic an, bn;
  int n_run = 0, n_fail = 0;
  logic [5:0] m = 0;

  always #4 clk = ~clk;

  ustep_phase_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .step_i(step), .dir_i(dir),
    .pos_o(pos), .a_mag_o(am), .a_neg_o(an), .b_mag_o(bm), .b_neg_o(bn)
  );

  function automatic int tab(input int k);
    int t [17] = '{0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100};
    return t[k];
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (pos model %0d)", req, act, exp_v, m);
    end
  endtask

  task automatic check_all(input string pos_req);
    int q = m[5:4], f = m[3:0];
    int ea = q[0] ? tab(16 - f) : tab(f);
    int eb = q[0] ? tab(f) : tab(16 - f);
    if (!en) begin ea = 0; eb = 0; end
    chk(pos_req, pos, m);
    chk(en ? "R8" : "R5", am, ea);
    chk(en ? "R8" : "R5", bm, eb);
    chk("R9", an, q[1]);
    chk("R9", bn, q[1] ^ q[0]);
    if (en) begin
      int s = am * am + bm * bm;
      chk("R10", (s >= 9800 && s <= 10200), 1);
    end
    if (en && m <= 16) begin
      chk("R6", am, tab(m));
      chk("R7", bm, tab(16 - m));
    end
  endtask

  task automatic cyc(input logic e, input logic s, input logic d, input string req);
    @(negedge clk);
    en = e; step = s; dir = d;
    @(posedge clk);
    if (e && s) m = d ? m + 6'd1 : m - 6'd1;
    #2;
    check_all(req);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #10 rst_n = 1;
    @(negedge clk); en = 1; #1;
    chk("R1", pos, 0); chk("R1", am, 0); chk("R1", bm, 100);
    chk("R1", an, 0);  chk("R1", bn, 0);
    // forward sweep through the wrap
    for (int i = 0; i < 70; i++) cyc(1, 1, 1, "R2");
    // reverse right at the seam and back across it
    while (m != 0) cyc(1, 1, 1, "R2");
    for (int i = 0; i < 70; i++) cyc(1, 1, 0, "R3");
    // holds: no step, both directions
    for (int i = 0; i < 4; i++) cyc(1, 0, i[0], "R4");
    // step request in the cycle enable falls
    cyc(0, 1, 1, "R4");
    for (int i = 0; i < 3; i++) cyc(0, 1, i[0], "R5");
    cyc(1, 0, 0, "R4");
    // mixed pattern
    for (int i = 0; i < 300; i++)
      cyc((i % 7) != 3, (i % 3) != 1, ((i / 5) % 2) == 0, "R4");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule